// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment value and a 32-bit effective offset into a physical byte address for a legacy real addressing mode. The segment value is multiplied by sixteen and added to the offset, so every segment begins on a 16-byte boundary. The carry out of bit 19 is kept, so addresses slightly above 1 MiB can be reached.

Each segment has a fixed length of 64 KiB. Before a bus cycle starts, the block checks that every byte of a 1-, 2- or 4-byte access lies at or below offset 0xFFFF. If any byte falls beyond that limit, the block raises a general-protection fault, which is vector 13, and withholds the valid strobe. After reset, code fetches put all ones on the upper twelve address lines. This continues until the first intersegment jump or call, which the surrounding core reports as a one-cycle pulse.

Top module: `rm_addr_gen`

## Requirements
- R1: When no override applies, `phys_addr` equals `seg_val`*16 plus `eff_off[15:0]`. The sum is 21 bits wide and the carry into bit 20 is kept. Bits 31:21 are zero.
- R2: The access size code is mapped as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. With `req` high, `gp_fault` is 1 exactly when `eff_off` + bytes − 1, computed without wrap, is greater than 0xFFFF. With `req` low, `gp_fault` is 0.
- R3: `addr_valid` equals `req` and not `gp_fault`. On a fault, `phys_addr` and `byte_en` are still driven by the same rules.
- R4: From reset until the first far transfer, a cycle with `code_fetch`=1 drives `phys_addr[31:20]` to 0xFFF. Bits 19:0 still carry the sum.
- R5: A one-cycle `far_xfer` pulse clears the override at the next clock edge. From then on, code fetches follow R1 until the next reset.
- R6: A data access (`code_fetch`=0) is never overridden, whatever the override state.
- R7: `byte_en` is the access-size mask (0x1, 0x3 or 0xF) shifted left by `phys_addr[1:0]` and cut to 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; arms the code-fetch override |
| req | input | 1 | Access request this cycle |
| seg_val | input | 16 | Segment register value |
| eff_off | input | 32 | Effective offset |
| acc_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2/3 = 4 B |
| code_fetch | input | 1 | Access is relative to the code segment |
| far_xfer | input | 1 | One-cycle pulse when an intersegment jump or call has executed |
| phys_addr | output | 32 | Physical byte address |
| byte_en | output | 4 | Byte lanes within the 32-bit word |
| gp_fault | output | 1 | General-protection fault (vector 13) |
| addr_valid | output | 1 | Start a bus cycle |

## Verification
The bench builds the block with its default widths: a 16-bit segment, a 32-bit offset and a 64 KiB limit. It sweeps four segment values, including 0xFFFF, which produces the carry into bit 20. It also sweeps offsets grouped on both sides of the limit and at extreme 32-bit values, every size code, and both fetch types. This gives every way an access can straddle the limit and every byte-lane alignment. The whole sweep runs twice, once before and once after a far-transfer pulse, so the override is seen both while armed and once it has cleared.

// File: rtl/rm_addr_gen.sv
module rm_addr_gen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 32,
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 4,
  parameter int HI_LSB = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  eff_off,
  input  logic [1:0]        acc_size,
  input  logic              code_fetch,
  input  logic              far_xfer,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [3:0]        byte_en,
  output logic              gp_fault,
  output logic              addr_valid
);
  localparam int SUM_W = SEG_W + SHIFT + 1;
  localparam int HI_W  = ADDR_W - HI_LSB;
  localparam logic [OFF_W:0] LIMIT = OFF_W'((1 << SEG_W) - 1);

  logic              hi_force;
  logic [SUM_W-1:0]  sum;
  logic [OFF_W:0]    last_byte;
  logic [2:0]        span_m1;
  logic [3:0]        mask;
  logic [7:0]        mask_sh;
  logic              over;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hi_force <= 1'b1;
    else if (far_xfer) hi_force <= 1'b0;

  always_comb
    case (acc_size)
      2'd0:    begin span_m1 = 3'd0; mask = 4'b0001; end
      2'd1:    begin span_m1 = 3'd1; mask = 4'b0011; end
      default: begin span_m1 = 3'd3; mask = 4'b1111; end
    endcase

  assign last_byte = {1'b0, eff_off} + (OFF_W+1)'(span_m1);
  assign over      = last_byte > LIMIT;

  assign sum = {1'b0, seg_val, SHIFT'(0)} + SUM_W'(eff_off[SEG_W-1:0]);

  always_comb begin
    phys_addr = ADDR_W'(sum);
    if (hi_force && code_fetch)
      phys_addr[ADDR_W-1:HI_LSB] = {HI_W{1'b1}};
  end

  assign mask_sh    = {4'b0, mask} << phys_addr[1:0];
  assign byte_en    = mask_sh[3:0];
  assign gp_fault   = req && over;
  assign addr_valid = req && !over;

  a_r3_fault_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> !addr_valid);

  a_r2_legal_offset_small: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (eff_off < (OFF_W)'(1 << SEG_W)));

  a_r5_far_clears_override: assert property (@(posedge clk) disable iff (!rst_n)
    far_xfer |=> (phys_addr[ADDR_W-1:HI_LSB+1] == '0));

  a_r5_override_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_force |=> !hi_force);

  a_r6_data_never_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !code_fetch |-> (phys_addr[ADDR_W-1:HI_LSB+1] == '0));

  a_r7_lanes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (byte_en != 4'b0));
endmodule

// File: tb/rm_addr_gen_tb_top.sv
module rm_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] seg_val = '0;
  logic [31:0] eff_off = '0;
  logic [1:0]  acc_size = '0;
  logic        code_fetch = 1'b0;
  logic        far_xfer = 1'b0;
  logic [31:0] phys_addr;
  logic [3:0]  byte_en;
  logic        gp_fault;
  logic        addr_valid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rm_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .seg_val(seg_val), .eff_off(eff_off),
    .acc_size(acc_size), .code_fetch(code_fetch), .far_xfer(far_xfer),
    .phys_addr(phys_addr), .byte_en(byte_en), .gp_fault(gp_fault),
    .addr_valid(addr_valid)
  );

  task automatic apply(input logic [15:0] s, input logic [31:0] o,
                       input logic [1:0] sz, input logic cf, input logic rq,
                       input bit armed);
    longint     n, last;
    logic [31:0] exp_a;
    logic [7:0]  m;
    logic       exp_f, exp_v;
    @(negedge clk);
    seg_val = s; eff_off = o; acc_size = sz; code_fetch = cf; req = rq;
    #1;
    n     = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    last  = longint'(o) + n - 1;
    exp_f = rq && (last > 64'h0000_FFFF);
    exp_v = rq && !(last > 64'h0000_FFFF);
    exp_a = (32'(s) * 16) + 32'(o[15:0]);
    if (armed && cf) exp_a[31:20] = 12'hFFF;
    m = (8'((1 << n) - 1)) << exp_a[1:0];
    vectors++;
    if (phys_addr !== exp_a) begin
      errors++;
      $display("FAIL R1/R4/R6 phys_addr got %h exp %h (seg %h off %h cf %0d)", phys_addr, exp_a, s, o, cf);
    end
    if (gp_fault !== exp_f) begin
      errors++;
      $display("FAIL R2 gp_fault got %0d exp %0d (off %h sz %0d)", gp_fault, exp_f, o, sz);
    end
    if (addr_valid !== exp_v) begin
      errors++;
      $display("FAIL R3 addr_valid got %0d exp %0d (off %h sz %0d)", addr_valid, exp_v, o, sz);
    end
    if (byte_en !== m[3:0]) begin
      errors++;
      $display("FAIL R7 byte_en got %b exp %b (addr %h sz %0d)", byte_en, m[3:0], exp_a, sz);
    end
  endtask

  task automatic sweep(input bit armed);
    logic [15:0] segs [4] = '{16'h0000, 16'h0001, 16'h1234, 16'hFFFF};
    logic [31:0] offs [10] = '{32'h0, 32'h1, 32'h3, 32'hFFFC, 32'hFFFD, 32'hFFFE,
                               32'hFFFF, 32'h10000, 32'hFFFF_FFFF, 32'h8000_0001};
    for (int si = 0; si < 4; si++)
      for (int oi = 0; oi < 10; oi++)
        for (int z = 0; z < 4; z++)
          for (int c = 0; c < 2; c++)
            apply(segs[si], offs[oi], 2'(z), c[0], 1'b1, armed);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // reset state: R4 override armed, R2/R3 idle request
    apply(16'hF000, 32'h0000_FFF0, 2'd0, 1'b1, 1'b0, 1'b1);
    rst_n = 1'b1;
    apply(16'hF000, 32'h0000_FFF0, 2'd0, 1'b1, 1'b1, 1'b1);
    apply(16'h0000, 32'h0001_0000, 2'd1, 1'b0, 1'b0, 1'b1);
    sweep(1'b1);
    // R5: one-cycle far transfer clears the override
    @(negedge clk); far_xfer = 1'b1;
    @(negedge clk); far_xfer = 1'b0;
    sweep(1'b0);
    repeat (4) @(posedge clk);
    apply(16'hFFFF, 32'h0000_000F, 2'd2, 1'b1, 1'b1, 1'b0); // R5 stays cleared
    // R4: reset re-arms the override
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    apply(16'hFFFF, 32'h0000_000F, 2'd2, 1'b1, 1'b1, 1'b1);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule